// File: doc/BRIEF.md
# Clock Divider Output Bank

This block takes one fast VCO-rate clock and derives a free-running reference clock and three banks of three divided clocks each. Banks A and B are single-ended. Bank C is a differential pair per output. Every bank output has a drive-enable flag next to its value, so the pad ring can turn each pin into a high-impedance driver. While an output is disabled, its value bits sit low.

A 3-bit control word does two jobs. It chooses which bank outputs are driven, and it chooses whether bank A divides by 20 or by 10. The word arrives from outside the VCO domain, so it is synchronized first. A new word is applied only at the start of a reference period, where every divided clock begins its low phase, so no output ever produces a shortened pulse. An active-low asynchronous reset holds all dividers and forces fixed output levels.

With default parameters and a 500 MHz VCO, the reference runs at 25 MHz, bank A at 25 or 50 MHz, and banks B and C at 125 MHz.

Top module: `clkbank_div`

## Requirements
- R1: `ref_o` has a period of 20 VCO edges. It is low for the first 10 edges after reset release and high for the next 10, repeating. This holds for every control code.
- R2: Each enabled bank B output and each enabled bank C true output has a period of 4 edges (low 2, high 2), starting low on the first edge after reset release.
- R3: Enabled bank A outputs divide by 20 (same waveform as `ref_o`) unless the active code is 100 or 110. For those two codes they divide by 10: low for 5 edges, then high for 5, phase-aligned to the start of each reference period.
- R4: The enable masks per code, with bit i standing for output i, are given as code→(A,B,C): 000→(001,000,001); 001→(001,001,001); 010→(011,000,011); 011→(111,111,111); 100→(001,000,001); 101→(011,011,011); 110→(011,000,011); 111→(000,000,000).
- R5: A disabled output has its enable flag low and its value low. For bank C, both the true and the complement value are low.
- R6: For every enabled bank C output, `c_n_o[i]` is the inverse of `c_p_o[i]`.
- R7: While `rst_ni` is low, every enable flag is high, `ref_o`, `a_o`, `b_o` and `c_p_o` are all zero, and `c_n_o` is all ones.
- R8: During the first reference period after reset release (edges 1 to 20), code 010 is in force whatever `cfg_i` holds.
- R9: A code placed on `cfg_i` after edge m takes effect at the first edge k with k ≥ m+3 and (k−1) mod 20 = 0. Enable flags never change at any other edge.
- R10: Within each bank, all enabled outputs carry the same value on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | VCO-rate clock |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| cfg_i | input | 3 | Enable and divide-select code, asynchronous |
| ref_o | output | 1 | Reference clock, divide by 20 |
| a_o | output | 3 | Bank A clock values |
| a_en_o | output | 3 | Bank A drive enables |
| b_o | output | 3 | Bank B clock values |
| b_en_o | output | 3 | Bank B drive enables |
| c_p_o | output | 3 | Bank C true values |
| c_n_o | output | 3 | Bank C complement values |
| c_en_o | output | 3 | Bank C drive enables (true and complement together) |

## Verification
The assertions assume that `rst_ni` is released away from a clock edge. They also take for granted that the first two edges after release still carry reset-time state, so checks on enable changes and on rising enables look two samples back. `cfg_i` may change at any time. The bench changes it only on falling clock edges and spaces successive changes more than one reference period apart, so at most one code is pending at each period start. One change is placed two edges before a period boundary to exercise deferral to the following boundary.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;
  localparam int unsigned BANK_W = 3;
  localparam int unsigned CFG_W  = 3;
  localparam logic [CFG_W-1:0] CFG_DEFAULT = 3'b010;

  typedef logic [BANK_W-1:0] bank_mask_t;

  typedef struct packed {
    bank_mask_t a_en;
    logic       a_fast;
    bank_mask_t b_en;
    bank_mask_t c_en;
  } route_t;

  function automatic route_t route_decode(input logic [CFG_W-1:0] code);
    route_t r;
    r = '0;
    unique case (code)
      3'b000: begin r.a_en = 3'b001; r.c_en = 3'b001; end
      3'b001: begin r.a_en = 3'b001; r.b_en = 3'b001; r.c_en = 3'b001; end
      3'b010: begin r.a_en = 3'b011; r.c_en = 3'b011; end
      3'b011: begin r.a_en = 3'b111; r.b_en = 3'b111; r.c_en = 3'b111; end
      3'b100: begin r.a_en = 3'b001; r.a_fast = 1'b1; r.c_en = 3'b001; end
      3'b101: begin r.a_en = 3'b011; r.b_en = 3'b011; r.c_en = 3'b011; end
      3'b110: begin r.a_en = 3'b011; r.a_fast = 1'b1; r.c_en = 3'b011; end
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/clkbank_phase.sv
module clkbank_phase #(
  parameter int unsigned PERIOD = 20,
  parameter int unsigned PH_W   = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] ph_next_o,
  output logic            frame_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

  logic [PH_W-1:0] ph_q, ph_d;

  always_comb ph_d = (ph_q == LAST) ? '0 : ph_q + 1'b1;

  // reset to LAST so the first edge after release is phase 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= LAST;
    else         ph_q <= ph_d;
  end

  assign ph_next_o = ph_d;
  assign frame_o   = (ph_d == '0);

  AST_PHASE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q <= LAST) else $error("phase out of range"); // R1
endmodule

// File: rtl/clkbank_cfg.sv
module clkbank_cfg
  import clkbank_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             frame_i,
  output route_t           route_o
);
  logic [CFG_W-1:0] sync_q [SYNC_STAGES];
  logic [CFG_W-1:0] live_q, live_d;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    logic [CFG_W-1:0] src;
    if (s == 0) begin : g_first
      assign src = cfg_i;
    end else begin : g_next
      assign src = sync_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[s] <= CFG_DEFAULT;
      else         sync_q[s] <= src;
    end
  end

  // code only switches where all divided clocks start low
  always_comb live_d = frame_i ? sync_q[SYNC_STAGES-1] : live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= CFG_DEFAULT;
    else         live_q <= live_d;
  end

  assign route_o = route_decode(live_d);

  AST_CFG_HOLD_MIDFRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(live_q)) else $error("code changed mid-frame"); // R9
endmodule

// File: rtl/clkbank_lane.sv
module clkbank_lane #(
  parameter int unsigned PH_W     = 5,
  parameter int unsigned DIV_SLOW = 20,
  parameter int unsigned DIV_FAST = 10,
  parameter bit          INV      = 1'b0,
  parameter bit          RST_VAL  = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PH_W-1:0] ph_i,
  input  logic            en_i,
  input  logic            fast_i,
  output logic            q_o
);
  localparam logic [PH_W-1:0] SLOW_M = PH_W'(DIV_SLOW);
  localparam logic [PH_W-1:0] FAST_M = PH_W'(DIV_FAST);
  localparam logic [PH_W-1:0] SLOW_H = PH_W'(DIV_SLOW / 2);
  localparam logic [PH_W-1:0] FAST_H = PH_W'(DIV_FAST / 2);

  logic [PH_W-1:0] m_slow, m_fast;
  logic            wave, q_d;

  always_comb begin
    m_slow = ph_i % SLOW_M;
    m_fast = ph_i % FAST_M;
    wave   = fast_i ? (m_fast >= FAST_H) : (m_slow >= SLOW_H);
    q_d    = en_i & (wave ^ INV);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/clkbank_div.sv
module clkbank_div
  import clkbank_pkg::*;
#(
  parameter int unsigned REF_DIV     = 20,
  parameter int unsigned A_SLOW_DIV  = 20,
  parameter int unsigned A_FAST_DIV  = 10,
  parameter int unsigned HS_DIV      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  cfg_i,
  output logic        ref_o,
  output logic [2:0]  a_o,
  output logic [2:0]  a_en_o,
  output logic [2:0]  b_o,
  output logic [2:0]  b_en_o,
  output logic [2:0]  c_p_o,
  output logic [2:0]  c_n_o,
  output logic [2:0]  c_en_o
);
  localparam int unsigned PH_W = $clog2(REF_DIV);
  localparam logic [PH_W-1:0] REF_HALF = PH_W'(REF_DIV / 2);

  logic [PH_W-1:0] ph_next;
  logic            frame;
  route_t          rt;

  clkbank_phase #(.PERIOD(REF_DIV), .PH_W(PH_W)) u_phase (
    .clk_i, .rst_ni, .ph_next_o(ph_next), .frame_o(frame)
  );

  clkbank_cfg #(.SYNC_STAGES(SYNC_STAGES)) u_cfg (
    .clk_i, .rst_ni, .cfg_i, .frame_i(frame), .route_o(rt)
  );

  // all pins driven at their reset level while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_en_o <= '1;
      b_en_o <= '1;
      c_en_o <= '1;
    end else begin
      a_en_o <= rt.a_en;
      b_en_o <= rt.b_en;
      c_en_o <= rt.c_en;
    end
  end

  clkbank_lane #(.PH_W(PH_W), .DIV_SLOW(REF_DIV), .DIV_FAST(REF_DIV)) u_ref (
    .clk_i, .rst_ni, .ph_i(ph_next), .en_i(1'b1), .fast_i(1'b0), .q_o(ref_o)
  );

  for (genvar i = 0; i < BANK_W; i++) begin : g_out
    clkbank_lane #(.PH_W(PH_W), .DIV_SLOW(A_SLOW_DIV), .DIV_FAST(A_FAST_DIV)) u_a (
      .clk_i, .rst_ni, .ph_i(ph_next), .en_i(rt.a_en[i]), .fast_i(rt.a_fast), .q_o(a_o[i])
    );
    clkbank_lane #(.PH_W(PH_W), .DIV_SLOW(HS_DIV), .DIV_FAST(HS_DIV)) u_b (
      .clk_i, .rst_ni, .ph_i(ph_next), .en_i(rt.b_en[i]), .fast_i(1'b0), .q_o(b_o[i])
    );
    clkbank_lane #(.PH_W(PH_W), .DIV_SLOW(HS_DIV), .DIV_FAST(HS_DIV)) u_cp (
      .clk_i, .rst_ni, .ph_i(ph_next), .en_i(rt.c_en[i]), .fast_i(1'b0), .q_o(c_p_o[i])
    );
    clkbank_lane #(.PH_W(PH_W), .DIV_SLOW(HS_DIV), .DIV_FAST(HS_DIV),
                   .INV(1'b1), .RST_VAL(1'b1)) u_cn (
      .clk_i, .rst_ni, .ph_i(ph_next), .en_i(rt.c_en[i]), .fast_i(1'b0), .q_o(c_n_o[i])
    );

    AST_DIFF_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      c_en_o[i] |-> (c_n_o[i] == !c_p_o[i])) else $error("pair not complementary"); // R6
    AST_A_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) && $past(rst_ni, 2) && $rose(a_en_o[i]) |-> !a_o[i])
      else $error("bank A output enabled high"); // R9
  end

  AST_BANK_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((a_o & a_en_o) == '0) || ((a_o & a_en_o) == a_en_o)) &&
    (((b_o & b_en_o) == '0) || ((b_o & b_en_o) == b_en_o)) &&
    (((c_p_o & c_en_o) == '0) || ((c_p_o & c_en_o) == c_en_o)))
    else $error("bank outputs misaligned"); // R10

  AST_EN_AT_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(rst_ni, 2) && !$stable({a_en_o, b_en_o, c_en_o})
    |-> !ref_o && $past(ref_o)) else $error("enable change off frame"); // R9

  // high-run length of the reference, checked at each falling edge
  logic [PH_W-1:0] ref_hi_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ref_hi_q <= '0;
    else if (ref_o) ref_hi_q <= ref_hi_q + 1'b1;
    else            ref_hi_q <= '0;
  end

  AST_REF_DUTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ref_o) |-> ref_hi_q == REF_HALF) else $error("reference duty wrong"); // R1
endmodule

// File: tb/tb_clkbank_div.sv
`timescale 1ns/1ps
module tb_clkbank_div;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] cfg_i = 3'b011;
  logic       ref_o;
  logic [2:0] a_o, a_en_o, b_o, b_en_o, c_p_o, c_n_o, c_en_o;

  int checks = 0;
  int failures = 0;
  int k = 0;
  int drv_edge = 0;
  logic [2:0] drv_code = 3'b011;
  logic [2:0] prev_code = 3'b011;
  logic [2:0] eff = 3'b010;
  bit done = 1'b0;

  clkbank_div dut (
    .clk_i(clk), .rst_ni, .cfg_i, .ref_o, .a_o, .a_en_o, .b_o, .b_en_o,
    .c_p_o, .c_n_o, .c_en_o
  );

  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s k=%0d actual=%b expected=%b", req, k, act, exp);
    end
  endtask

  task automatic chk_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {a_en, a_fast, b_en, c_en} from the R4 table
  function automatic logic [9:0] route(logic [2:0] c);
    case (c)
      3'b000: return {3'b001, 1'b0, 3'b000, 3'b001};
      3'b001: return {3'b001, 1'b0, 3'b001, 3'b001};
      3'b010: return {3'b011, 1'b0, 3'b000, 3'b011};
      3'b011: return {3'b111, 1'b0, 3'b111, 3'b111};
      3'b100: return {3'b001, 1'b1, 3'b000, 3'b001};
      3'b101: return {3'b011, 1'b0, 3'b011, 3'b011};
      3'b110: return {3'b011, 1'b1, 3'b000, 3'b011};
      default: return '0;
    endcase
  endfunction

  task automatic step_check();
    int p;
    logic w20, w10, w4;
    logic [9:0] r;
    logic [2:0] ae, be, ce, aw;
    string ten;
    @(posedge clk);
    k++;
    if ((k - 1) % 20 == 0) begin
      if (k == 1)                 eff = 3'b010;      // R8
      else if (k >= drv_edge + 3) eff = drv_code;    // R9
      else                        eff = prev_code;
    end
    @(negedge clk);
    p   = (k - 1) % 20;
    w20 = (p >= 10);
    w10 = ((p % 10) >= 5);
    w4  = ((p % 4) >= 2);
    r   = route(eff);
    ae  = r[9:7];
    be  = r[5:3];
    ce  = r[2:0];
    aw  = {3{r[6] ? w10 : w20}};
    if (k <= 20) ten = "R8 enables";
    else if (drv_edge > 0 && (k - drv_edge) <= 45) ten = "R9 enables";
    else ten = "R4 enables";
    chk("R1 ref", {2'b00, ref_o}, {2'b00, w20});
    chk(ten, a_en_o, ae);
    chk(ten, b_en_o, be);
    chk(ten, c_en_o, ce);
    chk("R3 bank A", a_o, ae & aw);
    chk("R2 bank B", b_o, be & {3{w4}});
    chk("R2 bank C true", c_p_o, ce & {3{w4}});
    chk("R6 bank C complement", c_n_o, ce & {3{~w4}});
    chk("R5 disabled low", (a_o & ~a_en_o) | (b_o & ~b_en_o) | ((c_p_o | c_n_o) & ~c_en_o), 3'b000);
    // R10: enabled outputs of bank B agree
    chk("R10 bank B aligned", b_o, b_en_o & {3{|b_o}});
  endtask

  task automatic do_reset(logic [2:0] c);
    @(negedge clk);
    cfg_i = c;
    drv_code = c;
    prev_code = c;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 ref", {2'b00, ref_o}, 3'b000);
    chk("R7 single-ended", a_o | b_o | c_p_o, 3'b000);
    chk("R7 complement", c_n_o, 3'b111);
    chk("R7 enables", a_en_o & b_en_o & c_en_o, 3'b111);
    rst_ni = 1'b1;
    k = 0;
    drv_edge = 0;
  endtask

  task automatic apply_cfg(logic [2:0] c);
    prev_code = drv_code;
    drv_code = c;
    drv_edge = k;
    cfg_i = c;
  endtask

  task automatic measure(string req, bit use_ref, int exp);
    int r1 = -1;
    int r2 = -1;
    logic prev = 1'b0;
    logic cur;
    for (int i = 0; i < 60; i++) begin
      step_check();
      cur = use_ref ? ref_o : a_o[0];
      if (cur && !prev) begin
        if (r1 < 0) r1 = k;
        else if (r2 < 0) r2 = k;
      end
      prev = cur;
    end
    chk_int(req, r2 - r1, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // exhaustive sweep over all codes from reset (R1, R2, R3, R4, R5, R6, R7, R8)
    for (int code = 0; code < 8; code++) begin
      do_reset(3'(code));
      repeat (80) step_check();
    end
    do_reset(3'b100);
    repeat (25) step_check();
    measure("R3 fast period", 1'b0, 10);
    measure("R1 ref period", 1'b1, 20);
    do_reset(3'b011);
    repeat (25) step_check();
    measure("R3 slow period", 1'b0, 20);
    // mid-run changes, one placed two edges before a boundary (R9)
    do_reset(3'b011);
    repeat (30) step_check();
    apply_cfg(3'b101);
    repeat (29) step_check();
    apply_cfg(3'b110);
    repeat (50) step_check();
    apply_cfg(3'b000);
    repeat (40) step_check();
    apply_cfg(3'b111);
    repeat (40) step_check();
    apply_cfg(3'b001);
    repeat (45) step_check();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule